// File: doc/BRIEF.md
# Edge-Latched Legacy Interrupt Aggregator

This block gathers eleven legacy expansion-bus interrupt lines into one summary interrupt for a host processor. Each line is watched for a low-to-high transition. A transition latches a sticky status bit, so a short pulse is never lost. The sixteen possible bus line numbers do not map linearly onto status bits. Lines 0, 1, 2, 8 and 13 are not wired to anything. The remaining lines fill status bits 0 to 10 in a fixed order in which line 9 falls after line 12.

Software reaches the block through a four-register window with a write strobe, a 2-bit address and byte-wide data. The status bits are split across two byte registers. Software acknowledges a source by writing a one to its status bit. A second pair of registers holds an enable mask. The summary output is high while any enabled status bit is set. A priority encoder presents the lowest pending bit together with its original bus line number, so a handler can service sources one at a time and loop until nothing is pending.

Top module: `isa_irq_agg`

## Requirements
- R1: A status bit is set at the first clock edge that samples its line high after the same line was sampled low. A line that stays high does not set the bit again after software clears it. The edge history resets to low.
- R2: Status bits 0 through 10 are fed by bus lines 3, 4, 5, 6, 7, 10, 11, 12, 9, 14 and 15 respectively. Activity on lines 0, 1, 2, 8 and 13 changes no status bit.
- R3: Address 0 reads status bits 7..0. Address 1 reads status bits 10..8 in data bits 2..0, and its upper data bits read as zero. Reads are combinational from the address.
- R4: A write to address 0 or address 1 clears every status bit whose data bit is one, at the same bit positions used for reads. Bits written as zero are kept, and a write to one register leaves the other register's bits untouched.
- R5: When a new edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The enable mask is read/write. Address 2 holds mask bits 7..0, and address 3 holds mask bits 10..8 in data bits 2..0, with its upper bits reading as zero.
- R7: `irq_out` is high exactly when at least one status bit is set while its mask bit is also set.
- R8: `svc_valid` flags any pending (set and enabled) bit. `svc_bit` gives the lowest pending bit index, and `svc_line` gives that bit's bus line number. Both fields read zero when nothing is pending.
- R9: After reset, all status and mask bits are zero, `irq_out` is low and `svc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Bus interrupt lines indexed by line number |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_out | output | 1 | Summary interrupt to the host |
| svc_valid | output | 1 | A pending source exists |
| svc_bit | output | 4 | Lowest pending status bit index |
| svc_line | output | 4 | Bus line number of that bit |

## Verification
Single pulses are sent one line at a time on every valid line and on every unconnected line. These pulses separate a correct line-to-bit order from a swapped one, and show whether the unconnected lines stay inert. Pending sources are combined with mask settings to check that the encoder picks the lowest bit rather than the lowest line number, since line 9 sits above line 12. A line held high across an acknowledge separates edge capture from level capture. An edge that coincides with its own acknowledge exposes the wrong set-versus-clear priority. A long stretch of random line activity, writes and addresses then compares every output against a behavioural model on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC   = 11;
    localparam int NUM_LINES = 16;
    localparam int DATA_W    = 8;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int BIT_W     = $clog2(NUM_SRC);
    localparam int HI_BITS   = NUM_SRC - DATA_W;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT_LO = 2'd0,
        SEL_STAT_HI = 2'd1,
        SEL_MASK_LO = 2'd2,
        SEL_MASK_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [BIT_W-1:0]  bitn;
        logic [LINE_W-1:0] line;
    } svc_t;

    // status bit index -> bus line number
    function automatic logic [LINE_W-1:0] bit_to_line(input logic [BIT_W-1:0] b);
        logic [LINE_W-1:0] l;
        case (b)
            4'd0:    l = 4'd3;
            4'd1:    l = 4'd4;
            4'd2:    l = 4'd5;
            4'd3:    l = 4'd6;
            4'd4:    l = 4'd7;
            4'd5:    l = 4'd10;
            4'd6:    l = 4'd11;
            4'd7:    l = 4'd12;
            4'd8:    l = 4'd9;
            4'd9:    l = 4'd14;
            4'd10:   l = 4'd15;
            default: l = '0;
        endcase
        return l;
    endfunction

    // bus line number -> {valid, status bit index}, derived from the forward map
    function automatic logic [BIT_W:0] line_to_bit(input logic [LINE_W-1:0] l);
        logic [BIT_W:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bit_to_line(BIT_W'(i)) == l) r = {1'b1, BIT_W'(i)};
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_SRC-1:0]   rise
);

    logic [NUM_SRC-1:0] sel;
    logic [NUM_SRC-1:0] prev_q;

    // route valid lines onto their status positions; unwired lines fall away
    always_comb begin
        logic [BIT_W:0] hit;
        sel = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            hit = line_to_bit(LINE_W'(l));
            if (hit[BIT_W]) sel[hit[BIT_W-1:0]] = lines[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sel;
    end

    assign rise = sel & ~prev_q;

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] enable_q
);

    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] status_d;
    logic [NUM_SRC-1:0] enable_d;

    always_comb begin
        clr      = '0;
        enable_d = enable_q;
        if (wr) begin
            case (reg_sel_e'(addr))
                SEL_STAT_LO: clr[DATA_W-1:0]       = wdata;
                SEL_STAT_HI: clr[NUM_SRC-1:DATA_W] = wdata[HI_BITS-1:0];
                SEL_MASK_LO: enable_d[DATA_W-1:0]  = wdata;
                SEL_MASK_HI: enable_d[NUM_SRC-1:DATA_W] = wdata[HI_BITS-1:0];
                default: ;
            endcase
        end
        // a fresh edge overrides an acknowledge in the same cycle
        status_d = (status_q & ~clr) | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc
    import irq_agg_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output svc_t               svc
);

    always_comb begin
        svc = '0;
        // scan downward so the lowest pending index is written last
        for (int b = NUM_SRC - 1; b >= 0; b--) begin
            if (pend[b]) begin
                svc.valid = 1'b1;
                svc.bitn  = BIT_W'(b);
                svc.line  = bit_to_line(BIT_W'(b));
            end
        end
    end

endmodule

// File: rtl/isa_irq_agg.sv
module isa_irq_agg
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out,
    output logic                 svc_valid,
    output logic [BIT_W-1:0]     svc_bit,
    output logic [LINE_W-1:0]    svc_line
);

    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pend;
    svc_t               svc;

    irq_edge_capture u_edge (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_lines),
        .rise  (src_rise)
    );

    irq_status_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .rise     (src_rise),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .status_q (status_q),
        .enable_q (enable_q)
    );

    assign pend = status_q & enable_q;

    irq_lowest_enc u_enc (
        .pend (pend),
        .svc  (svc)
    );

    assign irq_out   = |pend;
    assign svc_valid = svc.valid;
    assign svc_bit   = svc.bitn;
    assign svc_line  = svc.line;

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_STAT_LO: bus_rdata = status_q[DATA_W-1:0];
            SEL_STAT_HI: bus_rdata = {{(DATA_W-HI_BITS){1'b0}}, status_q[NUM_SRC-1:DATA_W]};
            SEL_MASK_LO: bus_rdata = enable_q[DATA_W-1:0];
            SEL_MASK_HI: bus_rdata = {{(DATA_W-HI_BITS){1'b0}}, enable_q[NUM_SRC-1:DATA_W]};
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/isa_irq_agg_chk.sv
module isa_irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_out,
    input logic               svc_valid,
    input logic [BIT_W-1:0]   svc_bit,
    input logic [LINE_W-1:0]  svc_line,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] src_rise
);

    // R7
    summary_agrees_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == svc_valid);

    // R8
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        !svc_valid |-> (svc_bit == '0 && svc_line == '0));

    // R8
    svc_pending_chk: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> (((status_q & enable_q) >> svc_bit) & NUM_SRC'(1)) != '0);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (src_rise != '0) |=> ((status_q & $past(src_rise)) == $past(src_rise)));

    // R1
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~$past(status_q) & ~$past(src_rise)) == '0);

    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_MASK_LO) |=> enable_q[DATA_W-1:0] == $past(bus_wdata));

    // R4
    hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_STAT_HI && src_rise[NUM_SRC-1:DATA_W] == '0)
        |=> (status_q[NUM_SRC-1:DATA_W] & $past(bus_wdata[HI_BITS-1:0])) == '0);

endmodule

bind isa_irq_agg isa_irq_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .svc_valid (svc_valid),
    .svc_bit   (svc_bit),
    .svc_line  (svc_line),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .src_rise  (src_rise)
);

// File: tb/isa_irq_agg_tb.sv
`timescale 1ns/100ps
module isa_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_lines = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_out;
    logic        svc_valid;
    logic [3:0]  svc_bit;
    logic [3:0]  svc_line;

    int vectors = 0;
    int errors  = 0;
    bit live    = 0;
    bit done    = 0;

    int MAP [11] = '{3, 4, 5, 6, 7, 10, 11, 12, 9, 14, 15};

    always #2.5 clk = ~clk;

    isa_irq_agg u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .svc_valid (svc_valid),
        .svc_bit   (svc_bit),
        .svc_line  (svc_line)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] m_prev;
    logic [10:0] m_stat, m_en, m_set, m_clr;

    always @(posedge clk) begin
        if (rst) begin
            m_prev = '0; m_stat = '0; m_en = '0;
        end else begin
            m_set = '0;
            m_clr = '0;
            foreach (MAP[i])
                m_set[i] = irq_lines[MAP[i]] && !m_prev[MAP[i]];
            if (bus_wr) begin
                if (bus_addr == 2'd0) m_clr[7:0]  = bus_wdata;
                if (bus_addr == 2'd1) m_clr[10:8] = bus_wdata[2:0];
                if (bus_addr == 2'd2) m_en[7:0]   = bus_wdata;
                if (bus_addr == 2'd3) m_en[10:8]  = bus_wdata[2:0];
            end
            m_stat = (m_stat & ~m_clr) | m_set;
            m_prev = irq_lines;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !rst) begin
            int exp_rd, exp_bit, exp_line;
            bit exp_valid;
            logic [10:0] pend;
            pend = m_stat & m_en;
            case (bus_addr)
                2'd0: exp_rd = int'(m_stat[7:0]);
                2'd1: exp_rd = int'(m_stat[10:8]);
                2'd2: exp_rd = int'(m_en[7:0]);
                default: exp_rd = int'(m_en[10:8]);
            endcase
            exp_valid = 0; exp_bit = 0; exp_line = 0;
            for (int b = 0; b < 11; b++) begin
                if (pend[b] && !exp_valid) begin
                    exp_valid = 1; exp_bit = b; exp_line = MAP[b];
                end
            end
            if (bus_addr < 2) check("R3 rdata", int'(bus_rdata), exp_rd);
            else              check("R6 rdata", int'(bus_rdata), exp_rd);
            check("R7 irq_out",   int'(irq_out),   int'(pend != 0));
            check("R8 svc_valid", int'(svc_valid), int'(exp_valid));
            check("R8 svc_bit",   int'(svc_bit),   exp_bit);
            check("R8 svc_line",  int'(svc_line),  exp_line);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse(input int line);
        @(posedge clk); #1 irq_lines[line] = 1'b1;
        @(posedge clk); #1 irq_lines[line] = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        @(posedge clk); #1 bus_addr = a;
        #1 check(tag, int'(bus_rdata), exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        live = 1;

        // R9 reset state
        rd_chk("R9 stat_lo", 2'd0, 0);
        rd_chk("R9 stat_hi", 2'd1, 0);
        rd_chk("R9 mask_lo", 2'd2, 0);
        rd_chk("R9 mask_hi", 2'd3, 0);
        check("R9 irq_out", int'(irq_out), 0);
        check("R9 svc_valid", int'(svc_valid), 0);

        // R2 line 9 lands on status bit 8 (high register bit 0)
        pulse(9);
        rd_chk("R2 line9 hi", 2'd1, 1);
        rd_chk("R2 line9 lo", 2'd0, 0);
        check("R7 masked", int'(irq_out), 0);

        // R2 unwired lines set nothing
        pulse(0); pulse(1); pulse(2); pulse(8); pulse(13);
        rd_chk("R2 unwired lo", 2'd0, 0);
        rd_chk("R2 unwired hi", 2'd1, 1);

        // R6 mask readback
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd_chk("R6 mask_lo", 2'd2, 8'hFF);
        rd_chk("R6 mask_hi", 2'd3, 8'h07);
        check("R7 enabled", int'(irq_out), 1);
        check("R8 line9 bit", int'(svc_bit), 8);
        check("R8 line9 num", int'(svc_line), 9);

        // R8 lowest bit wins over lower line number ordering
        pulse(15); pulse(12);
        check("R8 bit7 before bit8", int'(svc_line), 12);
        pulse(3);
        check("R8 line3", int'(svc_line), 3);
        rd_chk("R2 lo bits", 2'd0, 8'h81);
        rd_chk("R2 hi bits", 2'd1, 8'h05);

        // R4 clear low only
        wr(2'd0, 8'h01);
        rd_chk("R4 lo cleared", 2'd0, 8'h80);
        rd_chk("R4 hi kept", 2'd1, 8'h05);
        check("R8 after ack", int'(svc_line), 12);
        wr(2'd1, 8'h01);
        rd_chk("R4 hi partial", 2'd1, 8'h04);
        wr(2'd0, 8'h80);
        wr(2'd1, 8'hFF);
        check("R7 all clear", int'(irq_out), 0);
        check("R8 idle line", int'(svc_line), 0);

        // R1 held level does not re-set
        @(posedge clk); #1 irq_lines[4] = 1'b1;
        rd_chk("R1 edge seen", 2'd0, 8'h02);
        wr(2'd0, 8'h02);
        repeat (3) @(posedge clk);
        rd_chk("R1 level ignored", 2'd0, 8'h00);
        @(posedge clk); #1 irq_lines[4] = 1'b0;

        // R5 edge and acknowledge in the same cycle
        pulse(3);
        @(posedge clk); #1 irq_lines[3] = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h01;
        @(posedge clk); #1 irq_lines[3] = 1'b0; bus_wr = 1'b0;
        rd_chk("R5 set wins", 2'd0, 8'h01);

        // random traffic, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            irq_lines = 16'($urandom);
            bus_wr    = ($urandom % 4) == 0;
            bus_addr  = 2'($urandom);
            bus_wdata = 8'($urandom);
        end
        @(posedge clk); #1 bus_wr = 1'b0;
        repeat (3) @(posedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule